// File: doc/BRIEF.md
# Tagged Token Operand Matching Unit

This block sits in the firing path of a dataflow processor and pairs the two operands of two-input instructions. A token arrives with a context (frame) identifier, an instruction address, a left/right side flag and a data word. The block looks up the instruction's code word over a same-cycle fetch port. The code word says whether the instruction takes one input or two, and gives a slot offset. For two-input instructions the frame identifier plus the offset selects one operand slot in a small on-chip slot store.

If the slot already holds the partner operand of the same context and instruction, the block emits a fire beat carrying both operands, ordered by side, and frees the slot. If the slot is empty, the token is parked there and the block emits a bubble, so the pipeline never stalls on a missing partner. Tokens for one-input instructions fire at once and never touch the slot store. A token that hits an occupied slot it cannot pair with is dropped and reported with an error bubble.

Top module: `opmatch_unit`

## Requirements
- R1: While rst_ni is low and after its release, out_valid_o is 0 and in_ready_o is 1, and every slot is empty, so the first two-input token after reset is parked.
- R2: in_ready_o equals !out_valid_o || out_ready_i. Each accepted token yields exactly one output beat on the next clock edge. A beat held with out_ready_i low keeps all its fields unchanged.
- R3: code_addr_o carries in_ip_i and code_word_i is read in the same cycle. Bit OFS_W of code_word_i set means a one-input instruction. Bits OFS_W-1:0 are the offset. The slot index is (in_fp_i + offset) modulo 2**SLOT_AW.
- R4: A two-input token that finds its slot empty is stored in it. Its beat is a bubble: out_fire_o=0, out_err_o=0, out_a_o=0, out_b_o=0.
- R5: A two-input token whose slot holds a token with the same frame and instruction but the other side produces a fire beat (out_fire_o=1, out_err_o=0) and leaves the slot empty.
- R6: In a fire beat from a pair, out_a_o is the left-side value (in_port_i=0) and out_b_o is the right-side value (in_port_i=1), whichever arrived first.
- R7: A one-input token fires at once with out_a_o equal to its data and out_b_o=0, and leaves the slot store unchanged.
- R8: A two-input token that meets a stored token of the same frame, instruction and side produces an error bubble (out_err_o=1, out_fire_o=0, operands 0). The stored token is kept and the new one is dropped.
- R9: A two-input token that meets a stored token with a different frame or instruction produces the same error bubble and leaves the slot unchanged.
- R10: Every output beat carries the frame and instruction of the token that produced it on out_fp_o and out_ip_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Token present |
| in_ready_o | output | 1 | Token taken this cycle when valid |
| in_fp_i | input | FP_W | Frame identifier of the token |
| in_ip_i | input | IP_W | Instruction address of the token |
| in_port_i | input | 1 | Operand side: 0 left, 1 right |
| in_data_i | input | DATA_W | Operand value |
| code_addr_o | output | IP_W | Code store address (the token's instruction) |
| code_word_i | input | OFS_W+1 | One-input flag (top bit) and slot offset |
| out_valid_o | output | 1 | Output beat present |
| out_ready_i | input | 1 | Consumer takes the beat |
| out_fire_o | output | 1 | Beat is an executable instruction (else bubble) |
| out_err_o | output | 1 | Beat reports a slot conflict |
| out_fp_o | output | FP_W | Frame identifier of the beat |
| out_ip_o | output | IP_W | Instruction address of the beat |
| out_a_o | output | DATA_W | Left operand, or the single operand |
| out_b_o | output | DATA_W | Right operand, zero otherwise |

## Verification
The properties assume that code_word_i is a pure function of code_addr_o that settles in the same cycle. They also assume that the token fields stay known while in_valid_i is high. The bench models the code store as a fixed function of the address and holds each token steady until it is taken. Random stimulus draws frames and instructions from a narrow set, so pairs, duplicates and slot collisions occur often, and output back-pressure is randomized. Directed sequences cover both arrival orders, a same-side duplicate and a collision between different tags.

// File: rtl/opm_pkg.sv
`timescale 1ns/1ps
package opm_pkg;
  typedef enum logic {PORT_LEFT = 1'b0, PORT_RIGHT = 1'b1} port_e;
  typedef enum logic [1:0] {ACT_STORE, ACT_PAIR, ACT_SOLO, ACT_CLASH} act_e;
endpackage

// File: rtl/opm_slot_store.sv
`timescale 1ns/1ps
module opm_slot_store #(
  parameter int AW     = 6,
  parameter int FP_W   = 6,
  parameter int IP_W   = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     rd_addr_i,
  output logic              rd_busy_o,
  output logic              rd_port_o,
  output logic [FP_W-1:0]   rd_fp_o,
  output logic [IP_W-1:0]   rd_ip_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic              wr_busy_i,
  input  logic              wr_port_i,
  input  logic [FP_W-1:0]   wr_fp_i,
  input  logic [IP_W-1:0]   wr_ip_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int DEPTH = 1 << AW;

  logic              busy_q [DEPTH];
  logic              port_q [DEPTH];
  logic [FP_W-1:0]   fp_q   [DEPTH];
  logic [IP_W-1:0]   ip_q   [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  // presence flags need reset; payload does not
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                busy_q[s] <= 1'b0;
      else if (wr_en_i && wr_addr_i == AW'(s))    busy_q[s] <= wr_busy_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      port_q[wr_addr_i] <= wr_port_i;
      fp_q[wr_addr_i]   <= wr_fp_i;
      ip_q[wr_addr_i]   <= wr_ip_i;
      data_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_busy_o = busy_q[rd_addr_i];
  assign rd_port_o = port_q[rd_addr_i];
  assign rd_fp_o   = fp_q[rd_addr_i];
  assign rd_ip_o   = ip_q[rd_addr_i];
  assign rd_data_o = data_q[rd_addr_i];
endmodule

// File: rtl/opm_match.sv
`timescale 1ns/1ps
module opm_match
  import opm_pkg::*;
#(
  parameter int FP_W   = 6,
  parameter int IP_W   = 8,
  parameter int DATA_W = 16
) (
  input  logic              solo_i,
  input  logic              tok_port_i,
  input  logic [FP_W-1:0]   tok_fp_i,
  input  logic [IP_W-1:0]   tok_ip_i,
  input  logic [DATA_W-1:0] tok_data_i,
  input  logic              slot_busy_i,
  input  logic              slot_port_i,
  input  logic [FP_W-1:0]   slot_fp_i,
  input  logic [IP_W-1:0]   slot_ip_i,
  input  logic [DATA_W-1:0] slot_data_i,
  output act_e              act_o,
  output logic [DATA_W-1:0] opa_o,
  output logic [DATA_W-1:0] opb_o,
  output logic              wr_en_o,
  output logic              wr_busy_o
);
  logic same_tag;
  assign same_tag = (slot_fp_i == tok_fp_i) && (slot_ip_i == tok_ip_i);

  always_comb begin
    act_o     = ACT_CLASH;
    opa_o     = '0;
    opb_o     = '0;
    wr_en_o   = 1'b0;
    wr_busy_o = 1'b0;
    if (solo_i) begin
      act_o = ACT_SOLO;
      opa_o = tok_data_i;
    end else if (!slot_busy_i) begin
      act_o     = ACT_STORE;
      wr_en_o   = 1'b1;
      wr_busy_o = 1'b1;
    end else if (same_tag && (slot_port_i != tok_port_i)) begin
      act_o   = ACT_PAIR;
      wr_en_o = 1'b1;
      if (tok_port_i == PORT_LEFT) begin
        opa_o = tok_data_i;
        opb_o = slot_data_i;
      end else begin
        opa_o = slot_data_i;
        opb_o = tok_data_i;
      end
    end
  end
endmodule

// File: rtl/opmatch_unit.sv
`timescale 1ns/1ps
module opmatch_unit
  import opm_pkg::*;
#(
  parameter int FP_W    = 6,
  parameter int IP_W    = 8,
  parameter int DATA_W  = 16,
  parameter int OFS_W   = 4,
  parameter int SLOT_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [FP_W-1:0]   in_fp_i,
  input  logic [IP_W-1:0]   in_ip_i,
  input  logic              in_port_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic [IP_W-1:0]   code_addr_o,
  input  logic [OFS_W:0]    code_word_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_fire_o,
  output logic              out_err_o,
  output logic [FP_W-1:0]   out_fp_o,
  output logic [IP_W-1:0]   out_ip_o,
  output logic [DATA_W-1:0] out_a_o,
  output logic [DATA_W-1:0] out_b_o
);
  localparam int SOLO_BIT = OFS_W;

  logic [SLOT_AW-1:0] slot_addr;
  logic               accept;
  logic               s_busy, s_port;
  logic [FP_W-1:0]    s_fp;
  logic [IP_W-1:0]    s_ip;
  logic [DATA_W-1:0]  s_data;
  act_e               act;
  logic [DATA_W-1:0]  opa, opb;
  logic               m_wr_en, m_wr_busy;

  assign code_addr_o = in_ip_i;
  assign slot_addr   = SLOT_AW'(in_fp_i) + SLOT_AW'(code_word_i[OFS_W-1:0]);
  assign in_ready_o  = !out_valid_o || out_ready_i;
  assign accept      = in_valid_i && in_ready_o;

  opm_slot_store #(
    .AW(SLOT_AW), .FP_W(FP_W), .IP_W(IP_W), .DATA_W(DATA_W)
  ) store_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_addr_i (slot_addr),
    .rd_busy_o (s_busy),
    .rd_port_o (s_port),
    .rd_fp_o   (s_fp),
    .rd_ip_o   (s_ip),
    .rd_data_o (s_data),
    .wr_en_i   (accept && m_wr_en),
    .wr_addr_i (slot_addr),
    .wr_busy_i (m_wr_busy),
    .wr_port_i (in_port_i),
    .wr_fp_i   (in_fp_i),
    .wr_ip_i   (in_ip_i),
    .wr_data_i (in_data_i)
  );

  opm_match #(
    .FP_W(FP_W), .IP_W(IP_W), .DATA_W(DATA_W)
  ) match_i (
    .solo_i      (code_word_i[SOLO_BIT]),
    .tok_port_i  (in_port_i),
    .tok_fp_i    (in_fp_i),
    .tok_ip_i    (in_ip_i),
    .tok_data_i  (in_data_i),
    .slot_busy_i (s_busy),
    .slot_port_i (s_port),
    .slot_fp_i   (s_fp),
    .slot_ip_i   (s_ip),
    .slot_data_i (s_data),
    .act_o       (act),
    .opa_o       (opa),
    .opb_o       (opb),
    .wr_en_o     (m_wr_en),
    .wr_busy_o   (m_wr_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_fire_o  <= 1'b0;
      out_err_o   <= 1'b0;
      out_fp_o    <= '0;
      out_ip_o    <= '0;
      out_a_o     <= '0;
      out_b_o     <= '0;
    end else if (in_ready_o) begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        out_fire_o <= (act == ACT_PAIR) || (act == ACT_SOLO);
        out_err_o  <= (act == ACT_CLASH);
        out_fp_o   <= in_fp_i;
        out_ip_o   <= in_ip_i;
        out_a_o    <= opa;
        out_b_o    <= opb;
      end
    end
  end
endmodule

// File: rtl/opmatch_unit_chk.sv
`timescale 1ns/1ps
module opmatch_unit_chk #(
  parameter int FP_W    = 6,
  parameter int IP_W    = 8,
  parameter int DATA_W  = 16,
  parameter int OFS_W   = 4,
  parameter int SLOT_AW = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [FP_W-1:0]   in_fp_i,
  input logic [IP_W-1:0]   in_ip_i,
  input logic              in_port_i,
  input logic [DATA_W-1:0] in_data_i,
  input logic [IP_W-1:0]   code_addr_o,
  input logic [OFS_W:0]    code_word_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic              out_fire_o,
  input logic              out_err_o,
  input logic [FP_W-1:0]   out_fp_o,
  input logic [IP_W-1:0]   out_ip_o,
  input logic [DATA_W-1:0] out_a_o,
  input logic [DATA_W-1:0] out_b_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_idle_chk: assert (!out_valid_o);
    end
  end

  // R2
  accept_gives_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  // R2
  no_spurious_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(in_valid_i && in_ready_o) && (!out_valid_o || out_ready_i)) |=> !out_valid_o);

  // R2
  held_beat_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_fire_o) && $stable(out_err_o)
      && $stable(out_fp_o) && $stable(out_ip_o) && $stable(out_a_o) && $stable(out_b_o)));

  // R4
  bubble_zero_ops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_fire_o) |-> (out_a_o == '0 && out_b_o == '0));

  // R8
  err_is_bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_err_o) |-> !out_fire_o);

  // R7
  solo_fires_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && code_word_i[OFS_W]) |=>
      (out_valid_o && out_fire_o && !out_err_o && out_a_o == $past(in_data_i) && out_b_o == '0));

  // R10
  tag_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (out_fp_o == $past(in_fp_i) && out_ip_o == $past(in_ip_i)));
endmodule

bind opmatch_unit opmatch_unit_chk #(
  .FP_W(FP_W), .IP_W(IP_W), .DATA_W(DATA_W), .OFS_W(OFS_W), .SLOT_AW(SLOT_AW)
) chk_i (.*);

// File: tb/opmatch_unit_tb.sv
`timescale 1ns/1ps
module opmatch_unit_tb_top;
  localparam int FP_W = 6, IP_W = 8, DATA_W = 16, OFS_W = 4, SLOT_AW = 6;
  localparam int N_RAND = 3000;

  typedef struct packed {
    logic [2:0]        kind; // 0 store,1 pair,2 solo,3 dup,4 collide
    logic              fire;
    logic              err;
    logic [FP_W-1:0]   fp;
    logic [IP_W-1:0]   ip;
    logic [DATA_W-1:0] a;
    logic [DATA_W-1:0] b;
  } beat_t;

  typedef struct packed {
    logic [FP_W-1:0]   fp;
    logic [IP_W-1:0]   ip;
    logic              port;
    logic [DATA_W-1:0] data;
  } tok_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic in_valid_i = 1'b0, in_ready_o, in_port_i = 1'b0, out_ready_i = 1'b0;
  logic [FP_W-1:0] in_fp_i = '0;
  logic [IP_W-1:0] in_ip_i = '0, code_addr_o;
  logic [DATA_W-1:0] in_data_i = '0;
  logic [OFS_W:0] code_word_i;
  logic out_valid_o, out_fire_o, out_err_o;
  logic [FP_W-1:0] out_fp_o;
  logic [IP_W-1:0] out_ip_o;
  logic [DATA_W-1:0] out_a_o, out_b_o;

  always #2 clk = ~clk;

  function automatic logic [OFS_W:0] code_fn(logic [IP_W-1:0] ip);
    return {ip[1:0] == 2'b11, ip[5:2] ^ ip[7:4]};
  endfunction

  assign code_word_i = code_fn(code_addr_o);

  opmatch_unit #(.FP_W(FP_W), .IP_W(IP_W), .DATA_W(DATA_W), .OFS_W(OFS_W), .SLOT_AW(SLOT_AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_fp_i(in_fp_i), .in_ip_i(in_ip_i), .in_port_i(in_port_i), .in_data_i(in_data_i),
    .code_addr_o(code_addr_o), .code_word_i(code_word_i), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .out_fire_o(out_fire_o), .out_err_o(out_err_o),
    .out_fp_o(out_fp_o), .out_ip_o(out_ip_o), .out_a_o(out_a_o), .out_b_o(out_b_o));

  int checks = 0, fails = 0;
  logic              m_v    [1 << SLOT_AW];
  logic              m_port [1 << SLOT_AW];
  logic [FP_W-1:0]   m_fp   [1 << SLOT_AW];
  logic [IP_W-1:0]   m_ip   [1 << SLOT_AW];
  logic [DATA_W-1:0] m_d    [1 << SLOT_AW];
  beat_t exp_q[$];
  tok_t  stim_q[$];

  function automatic string req_of(logic [2:0] k);
    case (k)
      3'd0: return "R4";
      3'd1: return "R5 R6";
      3'd2: return "R7";
      3'd3: return "R8";
      default: return "R9 R3";
    endcase
  endfunction

  function automatic beat_t predict(tok_t t);
    beat_t e;
    logic [OFS_W:0] w;
    logic [SLOT_AW-1:0] ad;
    w = code_fn(t.ip);
    e = '0;
    e.fp = t.fp;
    e.ip = t.ip;
    if (w[OFS_W]) begin
      e.kind = 3'd2; e.fire = 1'b1; e.a = t.data;
    end else begin
      ad = SLOT_AW'(t.fp) + SLOT_AW'(w[OFS_W-1:0]);
      if (!m_v[ad]) begin
        e.kind = 3'd0;
        m_v[ad] = 1'b1; m_port[ad] = t.port; m_fp[ad] = t.fp; m_ip[ad] = t.ip; m_d[ad] = t.data;
      end else if (m_fp[ad] == t.fp && m_ip[ad] == t.ip && m_port[ad] != t.port) begin
        e.kind = 3'd1; e.fire = 1'b1;
        e.a = t.port ? m_d[ad] : t.data;
        e.b = t.port ? t.data : m_d[ad];
        m_v[ad] = 1'b0;
      end else begin
        e.kind = (m_fp[ad] == t.fp && m_ip[ad] == t.ip) ? 3'd3 : 3'd4;
        e.err = 1'b1;
      end
    end
    return e;
  endfunction

  task automatic check_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic check_beat(beat_t e);
    checks++;
    if (out_fire_o !== e.fire || out_err_o !== e.err || out_fp_o !== e.fp ||
        out_ip_o !== e.ip || out_a_o !== e.a || out_b_o !== e.b) begin
      fails++;
      $display("FAIL %s R10: got fire=%0b err=%0b fp=%0d ip=%h a=%h b=%h expected fire=%0b err=%0b fp=%0d ip=%h a=%h b=%h",
               req_of(e.kind), out_fire_o, out_err_o, out_fp_o, out_ip_o, out_a_o, out_b_o,
               e.fire, e.err, e.fp, e.ip, e.a, e.b);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    tok_t cur;
    logic have_tok;
    logic stall_prev;
    logic rnd_phase;
    int   n_rand;
    logic [FP_W-1:0] fp_c;
    logic [FP_W+IP_W+1+2*DATA_W-1:0] held;
    void'($urandom(32'd20240611));
    for (int i = 0; i < (1 << SLOT_AW); i++) m_v[i] = 1'b0;
    repeat (3) @(negedge clk);
    check_bit("R1 out_valid in reset", out_valid_o, 1'b0);
    check_bit("R1 in_ready in reset", in_ready_o, 1'b1);
    rst_ni = 1'b1;
    @(negedge clk);
    check_bit("R1 out_valid after reset", out_valid_o, 1'b0);

    // left then right, right then left, duplicate, solo, collision
    stim_q.push_back('{fp: 6'd3, ip: 8'h10, port: 1'b0, data: 16'h1111});
    stim_q.push_back('{fp: 6'd3, ip: 8'h10, port: 1'b1, data: 16'h2222});
    stim_q.push_back('{fp: 6'd4, ip: 8'h10, port: 1'b1, data: 16'h3333});
    stim_q.push_back('{fp: 6'd4, ip: 8'h13, port: 1'b0, data: 16'h7777});
    stim_q.push_back('{fp: 6'd4, ip: 8'h10, port: 1'b0, data: 16'h4444});
    stim_q.push_back('{fp: 6'd10, ip: 8'h10, port: 1'b0, data: 16'h5555});
    stim_q.push_back('{fp: 6'd10, ip: 8'h10, port: 1'b0, data: 16'h6666});
    fp_c = 6'd10 + FP_W'(code_fn(8'h10)) - FP_W'(code_fn(8'h20));
    stim_q.push_back('{fp: fp_c, ip: 8'h20, port: 1'b1, data: 16'h8888});
    stim_q.push_back('{fp: 6'd10, ip: 8'h10, port: 1'b1, data: 16'h9999});

    have_tok = 1'b0; stall_prev = 1'b0; rnd_phase = 1'b0; n_rand = 0; held = '0;
    forever begin
      @(negedge clk);
      if (stall_prev) check_bit("R2 held beat stable",
        ({out_fp_o, out_ip_o, out_fire_o, out_a_o, out_b_o} == held), 1'b1);
      if (stim_q.size() == 0) rnd_phase = 1'b1;
      out_ready_i = rnd_phase ? (($urandom % 4) != 0) : 1'b1;
      if (!have_tok) begin
        if (stim_q.size() != 0) begin
          cur = stim_q.pop_front(); have_tok = 1'b1;
        end else if (n_rand < N_RAND && ($urandom % 6) != 0) begin
          cur.fp = FP_W'($urandom % 6);
          cur.ip = IP_W'(($urandom % 10) * 23);
          cur.port = 1'($urandom);
          cur.data = DATA_W'($urandom);
          have_tok = 1'b1; n_rand++;
        end
      end
      in_valid_i = have_tok;
      in_fp_i = cur.fp; in_ip_i = cur.ip; in_port_i = cur.port; in_data_i = cur.data;
      #1;
      check_bit("R2 in_ready", in_ready_o, !out_valid_o || out_ready_i);
      if (out_valid_o && out_ready_i) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2: got extra beat expected none");
        end else check_beat(exp_q.pop_front());
      end
      stall_prev = out_valid_o && !out_ready_i;
      held = {out_fp_o, out_ip_o, out_fire_o, out_a_o, out_b_o};
      if (in_valid_i && in_ready_o) begin
        exp_q.push_back(predict(cur));
        have_tok = 1'b0;
      end
      if (!have_tok && stim_q.size() == 0 && n_rand >= N_RAND && exp_q.size() == 0 && !out_valid_o)
        break;
    end
    in_valid_i = 1'b0;
    summary();
  end
endmodule